// File: doc/BRIEF.md
# Queued Serial Command Sequencer with Status

This block walks a circular queue of command slots. It starts at a programmable first index and stops at a programmable last index. For each slot it hands one transfer to an external shift engine through a start/done handshake. Only one transfer is outstanding at a time. The bit-level shifting and the command storage live outside the block. The sequencer supplies only the slot index, with a one-cycle start strobe, and waits for the engine's completion pulse.

Alongside the stepping, the block keeps a small status word:
- a queue-finished flag;
- a mode-fault flag, raised when another master pulls the slave-select line low while this node is an active master;
- a halt-acknowledge flag;
- a completed-slot pointer that names the last slot whose transfer finished.

Software clears flags by writing ones. A halt can come from a software request or from an external freeze input, when freeze is enabled. A halt is honoured only between transfers. Two interrupt enables route the finished and halted flags to a single request line.

The queue runs once and then disables itself, unless wraparound is on. With wraparound on, it returns to the first slot after the last one and raises the finished flag again on each pass.

Top module: `qseq_ctrl`

## Requirements
- R1: After reset, `seq_active`, `xfer_start`, all three status flags, `irq_out` and `st_cptr` are 0.
- R2: A `go` pulse while idle loads the first index and activates the sequencer. Slots are then issued in ascending order, each by a single-cycle `xfer_start` with the slot on `xfer_idx`. No new start is issued until `xfer_done` has acknowledged the previous one.
- R3: Stepping is modulo 16 (4-bit pointers): when the last index is below the first, the slot after 15 is 0.
- R4: `st_cptr` takes the slot index in the cycle after that slot's `xfer_done`. It changes at no other time, so while the first slot of a new run executes it still shows the previous run's last slot (0 after reset).
- R5: Completion of the last-index slot sets `st_done`. Without wraparound, `seq_active` drops at the same time.
- R6: With `cfg_wrap` set, the slot after the last index is the first index again. `st_done` is set again on every pass, even after software has cleared it.
- R7: While `halt_req` is high, no new transfer starts. A transfer already started still completes, and `st_halta` is set once no transfer is outstanding. Issuing resumes when `halt_req` falls.
- R8: `freeze_in` acts like `halt_req` only when `frz_en` is 1. With `frz_en` at 0 it is ignored.
- R9: With `cfg_master` high and the sequencer active, `ss_n` low sets `st_modf`, clears `seq_active` in the next cycle, and abandons the outstanding transfer. `ss_n` low has no effect when `cfg_master` is 0.
- R10: `stat_clr` clears flags by writing ones: bit 0 clears `st_done`, bit 1 clears `st_modf`, bit 2 clears `st_halta`. A set condition in the same cycle wins over the clear.
- R11: `irq_out` is high while (`st_halta` and `ie_halt`) or (`st_done` and `ie_done`).
- R12: A `go` pulse while the sequencer is active is ignored, and the running order continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse, accepted only while idle |
| cfg_first | input | 4 | First slot index of the queue |
| cfg_last | input | 4 | Last slot index of the queue |
| cfg_wrap | input | 1 | Wraparound enable |
| cfg_master | input | 1 | Node operates as bus master |
| halt_req | input | 1 | Software halt request |
| freeze_in | input | 1 | External freeze |
| frz_en | input | 1 | Lets freeze_in halt the queue |
| ie_done | input | 1 | Interrupt enable for st_done |
| ie_halt | input | 1 | Interrupt enable for st_halta |
| ss_n | input | 1 | Slave-select input, active low |
| stat_clr | input | 3 | Write-one-to-clear strobes {halta, modf, done} |
| xfer_done | input | 1 | Shift engine completion pulse |
| xfer_start | output | 1 | Single-cycle transfer start strobe |
| xfer_idx | output | 4 | Slot index of the current transfer |
| seq_active | output | 1 | Sequencer enabled |
| st_done | output | 1 | Queue finished flag |
| st_modf | output | 1 | Mode-fault flag |
| st_halta | output | 1 | Halt acknowledge flag |
| st_cptr | output | 4 | Last completed slot |
| irq_out | output | 1 | Interrupt request |

## Verification
The queue is run with several slot patterns:
- a plain ascending range, which shows order and auto-disable;
- a range crossing slot 15, which separates modulo stepping from saturation;
- a single slot, which shows that the completed pointer holds the previous run's value;
- a wrapping pair cleared between passes, which shows that the finished flag re-arms.

The engine answers with zero-latency and multi-cycle completions. This shows that a halt raised mid-transfer waits for the boundary, and that a second `go` during a run leaves the order untouched.

Freeze is applied with and without its enable, and a low slave-select is applied with the master bit off and then on. These cases separate the ignored stimulus from the halting or faulting one.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
    localparam int NFLAG    = 3;
    localparam int FL_DONE  = 0;
    localparam int FL_MODF  = 1;
    localparam int FL_HALTA = 2;
endpackage

// File: rtl/qseq_step.sv
// Pointer advance: next slot and whether the current slot ends the queue.
module qseq_step #(
    parameter int PTR_W = 4
) (
    input  logic [PTR_W-1:0] cur,
    input  logic [PTR_W-1:0] first,
    input  logic [PTR_W-1:0] last,
    input  logic             wrap,
    output logic [PTR_W-1:0] nxt,
    output logic             at_last
);
    always_comb begin
        at_last = (cur == last);
        if (at_last) begin
            nxt = wrap ? first : cur;
        end else begin
            nxt = cur + PTR_W'(1);   // modulo 2**PTR_W
        end
    end
endmodule

// File: rtl/qseq_flags.sv
// Write-one-to-clear flag bank, set has priority.
module qseq_flags #(
    parameter int N = 3
) (
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    input  logic [N-1:0] cur_v,
    output logic [N-1:0] nxt_v
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        assign nxt_v[i] = set_v[i] | (cur_v[i] & ~clr_v[i]);
    end
endmodule

// File: rtl/qseq_ctrl.sv
module qseq_ctrl
    import qseq_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [PTR_W-1:0] cfg_first,
    input  logic [PTR_W-1:0] cfg_last,
    input  logic             cfg_wrap,
    input  logic             cfg_master,
    input  logic             halt_req,
    input  logic             freeze_in,
    input  logic             frz_en,
    input  logic             ie_done,
    input  logic             ie_halt,
    input  logic             ss_n,
    input  logic [NFLAG-1:0] stat_clr,
    input  logic             xfer_done,
    output logic             xfer_start,
    output logic [PTR_W-1:0] xfer_idx,
    output logic             seq_active,
    output logic             st_done,
    output logic             st_modf,
    output logic             st_halta,
    output logic [PTR_W-1:0] st_cptr,
    output logic             irq_out
);
    typedef struct packed {
        logic             en;
        logic             busy;
        logic             start;
        logic [PTR_W-1:0] ptr;
        logic [PTR_W-1:0] cptr;
        logic [NFLAG-1:0] flags;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic             hold, fault, complete, issue;
    logic [PTR_W-1:0] step_nxt;
    logic             step_last;
    logic [NFLAG-1:0] set_v, flags_nxt;

    qseq_step #(.PTR_W(PTR_W)) step_i (
        .cur     (s_q.ptr),
        .first   (cfg_first),
        .last    (cfg_last),
        .wrap    (cfg_wrap),
        .nxt     (step_nxt),
        .at_last (step_last)
    );

    qseq_flags #(.N(NFLAG)) flags_i (
        .set_v (set_v),
        .clr_v (stat_clr),
        .cur_v (s_q.flags),
        .nxt_v (flags_nxt)
    );

    always_comb begin
        hold     = halt_req | (freeze_in & frz_en);
        fault    = cfg_master & s_q.en & ~ss_n;
        complete = s_q.busy & xfer_done & ~fault;
        issue    = s_q.en & ~s_q.busy & ~hold & ~fault;

        set_v           = '0;
        set_v[FL_DONE]  = complete & step_last;
        set_v[FL_MODF]  = fault;
        set_v[FL_HALTA] = hold & ~s_q.busy;

        s_d       = s_q;
        s_d.start = 1'b0;
        if (fault) begin
            s_d.en   = 1'b0;
            s_d.busy = 1'b0;
        end else begin
            if (complete) begin
                s_d.busy = 1'b0;
                s_d.cptr = s_q.ptr;
                s_d.ptr  = step_nxt;
                if (step_last && !cfg_wrap) begin
                    s_d.en = 1'b0;
                end
            end
            if (issue) begin
                s_d.busy  = 1'b1;
                s_d.start = 1'b1;
            end
            if (!s_q.en && go) begin
                s_d.en  = 1'b1;
                s_d.ptr = cfg_first;
            end
        end
        s_d.flags = flags_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign xfer_start = s_q.start;
    assign xfer_idx   = s_q.ptr;
    assign seq_active = s_q.en;
    assign st_done    = s_q.flags[FL_DONE];
    assign st_modf    = s_q.flags[FL_MODF];
    assign st_halta   = s_q.flags[FL_HALTA];
    assign st_cptr    = s_q.cptr;
    assign irq_out    = (st_halta & ie_halt) | (st_done & ie_done);
endmodule

// File: rtl/qseq_ctrl_chk.sv
module qseq_ctrl_chk #(
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_master,
    input logic             halt_req,
    input logic             ss_n,
    input logic             xfer_done,
    input logic             xfer_start,
    input logic             seq_active,
    input logic             st_done,
    input logic             st_modf,
    input logic [PTR_W-1:0] st_cptr
);
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start); // R2

    AST_START_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> seq_active); // R2

    AST_CPTR_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_done |=> $stable(st_cptr)); // R4

    AST_DONE_FROM_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_done) |-> $past(xfer_done)); // R5

    AST_HALT_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req ##1 halt_req |-> !xfer_start); // R7

    AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && seq_active && !ss_n) |=> (!seq_active && st_modf)); // R9
endmodule

bind qseq_ctrl qseq_ctrl_chk #(.PTR_W(PTR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_master (cfg_master),
    .halt_req   (halt_req),
    .ss_n       (ss_n),
    .xfer_done  (xfer_done),
    .xfer_start (xfer_start),
    .seq_active (seq_active),
    .st_done    (st_done),
    .st_modf    (st_modf),
    .st_cptr    (st_cptr)
);

// File: tb/qseq_ctrl_tb_top.sv
`timescale 1ns/100ps
module qseq_ctrl_tb_top;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0;
    logic [3:0] cfg_first = '0, cfg_last = '0;
    logic       cfg_wrap = 1'b0, cfg_master = 1'b0, halt_req = 1'b0;
    logic       freeze_in = 1'b0, frz_en = 1'b0, ie_done = 1'b0, ie_halt = 1'b0;
    logic       ss_n = 1'b1;
    logic [2:0] stat_clr = '0;
    logic       xfer_done = 1'b0;
    logic       xfer_start, seq_active, st_done, st_modf, st_halta, irq_out;
    logic [3:0] xfer_idx, st_cptr;

    always #2.5 clk = ~clk;

    qseq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .cfg_first(cfg_first), .cfg_last(cfg_last),
        .cfg_wrap(cfg_wrap), .cfg_master(cfg_master), .halt_req(halt_req),
        .freeze_in(freeze_in), .frz_en(frz_en), .ie_done(ie_done), .ie_halt(ie_halt),
        .ss_n(ss_n), .stat_clr(stat_clr), .xfer_done(xfer_done),
        .xfer_start(xfer_start), .xfer_idx(xfer_idx), .seq_active(seq_active),
        .st_done(st_done), .st_modf(st_modf), .st_halta(st_halta),
        .st_cptr(st_cptr), .irq_out(irq_out)
    );

    int n_chk = 0, n_fail = 0;
    int issued[$];
    int lat = 2;
    int cnt = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge
    int m_en, m_busy, m_start, m_ptr, m_cptr, m_done, m_modf, m_halta;
    always @(posedge clk) begin
        int hold, fault, fin, n_en, n_busy, n_ptr, n_cptr, s_done, s_halta;
        if (!rst_n) begin
            m_en = 0; m_busy = 0; m_start = 0; m_ptr = 0; m_cptr = 0;
            m_done = 0; m_modf = 0; m_halta = 0;
        end else begin
            hold  = (halt_req || (freeze_in && frz_en)) ? 1 : 0;
            fault = (cfg_master && m_en != 0 && !ss_n) ? 1 : 0;
            fin   = (m_busy != 0 && xfer_done && fault == 0) ? 1 : 0;
            n_en = m_en; n_busy = m_busy; n_ptr = m_ptr; n_cptr = m_cptr;
            s_done = 0; s_halta = (hold != 0 && m_busy == 0) ? 1 : 0;
            m_start = 0;
            if (fault != 0) begin
                n_en = 0; n_busy = 0;
            end else begin
                if (fin != 0) begin
                    n_busy = 0; n_cptr = m_ptr;
                    if (m_ptr == int'(cfg_last)) begin
                        s_done = 1;
                        if (cfg_wrap) n_ptr = int'(cfg_first); else n_en = 0;
                    end else begin
                        n_ptr = (m_ptr + 1) % DEPTH;
                    end
                end
                if (m_en != 0 && m_busy == 0 && hold == 0) begin
                    n_busy = 1; m_start = 1;
                end
                if (m_en == 0 && go) begin
                    n_en = 1; n_ptr = int'(cfg_first);
                end
            end
            m_done  = (s_done != 0 || (m_done != 0 && !stat_clr[0])) ? 1 : 0;
            m_modf  = (fault != 0  || (m_modf != 0 && !stat_clr[1])) ? 1 : 0;
            m_halta = (s_halta != 0 || (m_halta != 0 && !stat_clr[2])) ? 1 : 0;
            m_en = n_en; m_busy = n_busy; m_ptr = n_ptr; m_cptr = n_cptr;
        end
    end

    // Compare on falling edge, then emulate the shift engine
    always @(negedge clk) begin
        int m_irq;
        m_irq = ((m_halta != 0 && ie_halt) || (m_done != 0 && ie_done)) ? 1 : 0;
        chk("R2 xfer_start", int'(xfer_start), m_start);
        chk("R2 xfer_idx", int'(xfer_idx), m_ptr);
        chk("R5 seq_active", int'(seq_active), m_en);
        chk("R4 st_cptr", int'(st_cptr), m_cptr);
        chk("R5 st_done", int'(st_done), m_done);
        chk("R9 st_modf", int'(st_modf), m_modf);
        chk("R7 st_halta", int'(st_halta), m_halta);
        chk("R11 irq_out", int'(irq_out), m_irq);
        if (xfer_start) issued.push_back(int'(xfer_idx));
        xfer_done <= 1'b0;
        if (!seq_active) cnt = 0;
        if (xfer_start) begin
            if (lat == 0) xfer_done <= 1'b1; else cnt = lat;
        end else if (cnt > 0) begin
            cnt--;
            if (cnt == 0) xfer_done <= 1'b1;
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic pulse_go();
        go = 1'b1; cyc(1); go = 1'b0;
    endtask

    task automatic clr(logic [2:0] v);
        stat_clr = v; cyc(1); stat_clr = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && seq_active; i++) cyc(1);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400 && !st_done; i++) cyc(1);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int starts;
        cyc(3); rst_n = 1'b1; cyc(1);
        // R1 reset state
        chk("R1 active", int'(seq_active), 0);
        chk("R1 flags", int'({st_done, st_modf, st_halta}), 0);
        chk("R1 cptr", int'(st_cptr), 0);
        chk("R1 irq", int'(irq_out), 0);

        // R2 / R5 plain ascending run
        cfg_first = 4'd2; cfg_last = 4'd5; lat = 2; issued = {};
        pulse_go(); wait_idle(); cyc(2);
        chk("R2 count", issued.size(), 4);
        foreach (issued[k]) chk("R2 order", issued[k], 2 + k);
        chk("R5 done", int'(st_done), 1);
        chk("R5 disabled", int'(seq_active), 0);
        chk("R4 cptr last", int'(st_cptr), 5);

        // R4 pointer holds previous run while the first slot executes
        clr(3'b001);
        chk("R10 done cleared", int'(st_done), 0);
        cfg_first = 4'd7; cfg_last = 4'd7; lat = 3;
        pulse_go(); cyc(2);
        chk("R4 cptr held", int'(st_cptr), 5);
        wait_idle(); cyc(2);
        chk("R4 cptr updated", int'(st_cptr), 7);

        // R3 crossing slot 15 with zero-latency engine
        clr(3'b001);
        cfg_first = 4'd14; cfg_last = 4'd1; lat = 0; issued = {};
        pulse_go(); wait_idle(); cyc(2);
        chk("R3 count", issued.size(), 4);
        if (issued.size() == 4) begin
            chk("R3 s0", issued[0], 14); chk("R3 s1", issued[1], 15);
            chk("R3 s2", issued[2], 0);  chk("R3 s3", issued[3], 1);
        end

        // R12 second go during a run is ignored
        clr(3'b001);
        cfg_first = 4'd0; cfg_last = 4'd3; lat = 3; issued = {};
        pulse_go(); cyc(4);
        cfg_first = 4'd9; pulse_go();
        wait_idle(); cyc(2);
        chk("R12 count", issued.size(), 4);
        foreach (issued[k]) chk("R12 order", issued[k], k);

        // R6 wraparound re-sets done on each pass
        clr(3'b001);
        cfg_first = 4'd4; cfg_last = 4'd5; cfg_wrap = 1'b1; ie_done = 1'b1;
        lat = 2; issued = {};
        pulse_go(); wait_done(); cyc(1);
        chk("R11 irq done", int'(irq_out), 1);
        clr(3'b001);
        chk("R6 cleared", int'(st_done), 0);
        wait_done();
        chk("R6 done again", int'(st_done), 1);
        chk("R6 back to first", issued.size() >= 3 ? issued[2] : -1, 4);
        chk("R6 still active", int'(seq_active), 1);
        ie_done = 1'b0; clr(3'b001);

        // R7 halt at a boundary, R10 set wins over clear
        halt_req = 1'b1; cyc(6);
        chk("R7 halta", int'(st_halta), 1);
        starts = issued.size(); cyc(10);
        chk("R7 no starts", issued.size(), starts);
        chk("R7 active", int'(seq_active), 1);
        ie_halt = 1'b1; cyc(1);
        chk("R11 irq halt", int'(irq_out), 1);
        clr(3'b100); cyc(1);
        chk("R10 set wins", int'(st_halta), 1);
        halt_req = 1'b0; ie_halt = 1'b0; cyc(8);
        chk("R7 resumed", int'(issued.size() > starts), 1);
        clr(3'b100);
        chk("R10 halta cleared", int'(st_halta), 0);

        // R9 master fault stops the queue
        cfg_master = 1'b1; ss_n = 1'b0; cyc(1); ss_n = 1'b1; cyc(1);
        chk("R9 modf", int'(st_modf), 1);
        chk("R9 stopped", int'(seq_active), 0);
        cfg_master = 1'b0; clr(3'b011);
        chk("R10 modf cleared", int'(st_modf), 0);

        // R8 freeze gated by frz_en
        cfg_first = 4'd0; cfg_last = 4'd1; lat = 1;
        pulse_go(); freeze_in = 1'b1; frz_en = 1'b0;
        starts = issued.size(); cyc(10);
        chk("R8 freeze ignored", int'(issued.size() > starts), 1);
        chk("R8 no halta", int'(st_halta), 0);
        frz_en = 1'b1; cyc(6);
        chk("R8 frozen halta", int'(st_halta), 1);
        starts = issued.size(); cyc(10);
        chk("R8 frozen no starts", issued.size(), starts);
        // R9 low select with master off is ignored
        ss_n = 1'b0; cyc(4);
        chk("R9 no modf slave", int'(st_modf), 0);
        chk("R9 still active", int'(seq_active), 1);
        ss_n = 1'b1; freeze_in = 1'b0; frz_en = 1'b0; cyc(4);
        cfg_master = 1'b1; ss_n = 1'b0; cyc(1); ss_n = 1'b1; cfg_master = 1'b0; cyc(2);
        chk("R9 fault stop", int'(seq_active), 0);
        cyc(4);
        summary();
    end
endmodule